// File: doc/BRIEF.md
# Ethernet PHY discovery and link-mode resolver

This block is a control sequencer that sits in front of an MDIO management port. On a start pulse it looks for an attached transceiver by reading its first identifier register at each management address in turn. It keeps the first address that returns a plausible identifier. It then checks whether the link is already up. If the link is down, it programs the advertised abilities and restarts auto-negotiation. It polls for negotiation completion and then for link, with a bounded number of spaced polls. Once the link is up, it reads the status registers and turns them into three MAC mode bits: gigabit, fast (100 Mb/s) and full duplex.

The management side uses a request/done handshake. The block presents one command at a time (address, register, write flag, write data) and holds it until a one-cycle done arrives with the read data. The outcome is reported as a one-cycle `done` pulse with a two-bit result code. The block also outputs the selected transceiver address, a link-up flag, and a MAC control word: the caller's control word with the three mode bits replaced.

Top module: `phy_link_resolver`

## Requirements
- R1: After `start`, register 2 is read at management addresses 0, 1, 2, … in ascending order. The first address whose value is neither 0xFFFF nor 0x0000 is selected and appears on `phy_addr`.
- R2: If none of the `NUM_ADDR` addresses passes the R1 test, `done` pulses with result 1, `link_up` stays 0 and `ctrl_out` keeps its previous value.
- R3: If bit 2 of status register 1, read once after selection, is set, no write is issued and the block goes straight to mode resolution.
- R4: Otherwise the block writes register 4 with 0x01E1 and then register 0 with 0x1200, in that order.
- R5: After the restart, register 1 is read until bit 5 is set. There are at most `POLL_MAX` reads, with `POLL_GAP` idle cycles after each failed read. If the budget runs out, `done` pulses with result 2.
- R6: After negotiation completes, register 1 is read until bit 2 is set, with a fresh budget of the same size. If that budget runs out, the result is 3.
- R7: With `GIGA_EN` set, register 10 is read during resolution. If bit 11 is set, the mode is gigabit plus full duplex. Otherwise, if bit 10 is set, the mode is gigabit alone. With `GIGA_EN` clear, register 10 is never read and the gigabit bit is never set.
- R8: If no gigabit case applies, register 1 decides, in this priority order: bit 14 gives fast plus full; bit 12 gives full only; bit 13 gives fast only; otherwise all three mode bits are 0.
- R9: On success, `ctrl_out` takes `ctrl_in` with bit 8 (full duplex), bit 9 (gigabit) and bit 11 (fast) replaced by the resolved mode. All other bits are copied from `ctrl_in`. `ctrl_out` changes at no other time.
- R10: `done` is a single-cycle pulse with result 0 on success, and `link_up` is 1 after a success and until the next `start`.
- R11: Only one management request is outstanding at a time. Its address, register, write flag and data are held unchanged from request until done, and the request is low in the cycle `done` is reported.
- R12: After reset, `done`, `link_up`, `mdio_req`, `result` and `ctrl_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a discovery run |
| mdio_req | output | 1 | Management command pending |
| mdio_wr | output | 1 | Command is a write (1) or read (0) |
| mdio_phy | output | 5 | Management address of the command |
| mdio_reg | output | 5 | Register number of the command |
| mdio_wdata | output | 16 | Write data |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| mdio_done | input | 1 | One-cycle completion of the pending command |
| ctrl_in | input | CTRL_W | MAC control word to be merged |
| ctrl_out | output | CTRL_W | Merged MAC control word |
| phy_addr | output | 5 | Selected transceiver address |
| link_up | output | 1 | Link established by the last run |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 no transceiver, 2 negotiation timeout, 3 link down |

## Verification
A wrong sequencer state shows up as a command on the management port with the wrong register, address or write value, or with a missing step. It therefore shows at the port during the very next request, not only at the end of a run. A miscounted poll budget moves the boundary between success and timeout by exactly one read. For that reason the bench places negotiation and link delays on both sides of `POLL_MAX`. A wrong priority in the resolver shows only in `ctrl_out` in the cycle `done` pulses. Ability combinations are chosen so that a higher-priority bit shadows a lower-priority one.

// File: rtl/plr_pkg.sv
package plr_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NO_PHY  = 2'd1,
    RES_AN_TMO  = 2'd2,
    RES_LINK_DN = 2'd3
  } plr_res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_STAT0, S_ADV, S_CTL,
    S_AN_RD, S_AN_GAP, S_LK_RD, S_LK_GAP, S_GSTAT, S_RSTAT
  } plr_state_e;

  typedef struct packed {
    logic giga;
    logic fast;
    logic full;
  } plr_mode_t;

  // management register numbers
  localparam logic [4:0] REG_CTL   = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID1   = 5'd2;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam logic [4:0] REG_GSTAT = 5'd10;

  // write values: all 10/100 abilities + selector; negotiation enable + restart
  localparam logic [15:0] ADV_VAL = 16'h01E1;
  localparam logic [15:0] CTL_VAL = 16'h1200;

  // status bit positions
  localparam int STAT_LINK   = 2;
  localparam int STAT_ANDONE = 5;
  localparam int STAT_10H    = 11;
  localparam int STAT_10F    = 12;
  localparam int STAT_100H   = 13;
  localparam int STAT_100F   = 14;
  localparam int GSTAT_1000H = 10;
  localparam int GSTAT_1000F = 11;

endpackage

// File: rtl/plr_rst_sync.sv
module plr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/plr_poll_timer.sv
module plr_poll_timer #(
  parameter int POLL_GAP = 25000,
  parameter int POLL_MAX = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fail,
  output logic gap_busy,
  output logic exhausted
);
  localparam int CNT_W = $clog2(POLL_MAX + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POLL_MAX);
  localparam logic [GAP_W-1:0] GAP_LD  = GAP_W'(POLL_GAP);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    cnt_d = cnt_q;
    gap_d = (gap_q != '0) ? gap_q - 1'b1 : gap_q;
    if (clear) begin
      cnt_d = '0;
      gap_d = '0;
    end else if (fail) begin
      cnt_d = cnt_q + 1'b1;
      gap_d = GAP_LD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      gap_q <= gap_d;
    end
  end

  assign gap_busy  = (gap_q != '0);
  assign exhausted = (cnt_q == CNT_MAX);

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R5
  AST_READ_WITH_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (cnt_q < CNT_MAX)); // R6
endmodule

// File: rtl/plr_mode_resolve.sv
module plr_mode_resolve
  import plr_pkg::*;
#(
  parameter bit GIGA_EN = 1'b1
) (
  input  logic [15:0] gstat,
  input  logic [15:0] stat,
  output plr_mode_t   mode
);
  logic g_full, g_half;

  generate
    if (GIGA_EN) begin : g_giga_on
      assign g_full = gstat[GSTAT_1000F];
      assign g_half = gstat[GSTAT_1000H];
    end else begin : g_giga_off
      assign g_full = 1'b0;
      assign g_half = 1'b0;
    end
  endgenerate

  always_comb begin
    mode = '0;
    if (g_full)               mode = '{giga: 1'b1, fast: 1'b0, full: 1'b1};
    else if (g_half)          mode = '{giga: 1'b1, fast: 1'b0, full: 1'b0};
    else if (stat[STAT_100F]) mode = '{giga: 1'b0, fast: 1'b1, full: 1'b1};
    else if (stat[STAT_10F])  mode = '{giga: 1'b0, fast: 1'b0, full: 1'b1};
    else if (stat[STAT_100H]) mode = '{giga: 1'b0, fast: 1'b1, full: 1'b0};
    else                      mode = '0;
  end
endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
  import plr_pkg::*;
#(
  parameter int NUM_ADDR = 32,
  parameter int POLL_GAP = 25000,
  parameter int POLL_MAX = 1000,
  parameter bit GIGA_EN  = 1'b1,
  parameter int CTRL_W   = 16,
  parameter int FULL_BIT = 8,
  parameter int GIGA_BIT = 9,
  parameter int FAST_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mdio_req,
  output logic              mdio_wr,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic [15:0]       mdio_rdata,
  input  logic              mdio_done,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [4:0]        phy_addr,
  output logic              link_up,
  output logic              done,
  output logic [1:0]        result
);
  localparam logic [4:0] LAST_ADDR = 5'(NUM_ADDR - 1);

  logic rst_sync_n;
  plr_state_e state_q, state_d;
  logic [4:0]        addr_q, addr_d;
  logic [15:0]       gstat_q, gstat_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              link_q, link_d;
  logic              done_q, done_d;
  plr_res_e          res_q, res_d;
  logic              tmr_clear, tmr_fail, gap_busy, exhausted;
  logic              id_ok;
  plr_mode_t         mode;

  plr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  plr_poll_timer #(
    .POLL_GAP (POLL_GAP),
    .POLL_MAX (POLL_MAX)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear     (tmr_clear),
    .fail      (tmr_fail),
    .gap_busy  (gap_busy),
    .exhausted (exhausted)
  );

  plr_mode_resolve #(
    .GIGA_EN (GIGA_EN)
  ) u_resolve (
    .gstat (gstat_q),
    .stat  (mdio_rdata),
    .mode  (mode)
  );

  assign id_ok = (mdio_rdata != 16'hFFFF) && (mdio_rdata != 16'h0000);

  // management command decode
  always_comb begin
    mdio_req   = 1'b1;
    mdio_wr    = 1'b0;
    mdio_reg   = REG_STAT;
    mdio_wdata = 16'h0000;
    unique case (state_q)
      S_SCAN:  mdio_reg = REG_ID1;
      S_STAT0, S_AN_RD, S_LK_RD, S_RSTAT: mdio_reg = REG_STAT;
      S_GSTAT: mdio_reg = REG_GSTAT;
      S_ADV: begin
        mdio_wr    = 1'b1;
        mdio_reg   = REG_ADV;
        mdio_wdata = ADV_VAL;
      end
      S_CTL: begin
        mdio_wr    = 1'b1;
        mdio_reg   = REG_CTL;
        mdio_wdata = CTL_VAL;
      end
      default: mdio_req = 1'b0;
    endcase
  end
  assign mdio_phy = addr_q;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    gstat_d   = gstat_q;
    ctrl_d    = ctrl_q;
    link_d    = link_q;
    res_d     = res_q;
    done_d    = 1'b0;
    tmr_clear = 1'b0;
    tmr_fail  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        addr_d  = 5'd0;
        link_d  = 1'b0;
        state_d = S_SCAN;
      end
      S_SCAN: if (mdio_done) begin
        if (id_ok)                  state_d = S_STAT0;
        else if (addr_q == LAST_ADDR) begin
          done_d  = 1'b1;
          res_d   = RES_NO_PHY;
          state_d = S_IDLE;
        end else                    addr_d = addr_q + 5'd1;
      end
      S_STAT0: if (mdio_done) begin
        if (mdio_rdata[STAT_LINK]) state_d = GIGA_EN ? S_GSTAT : S_RSTAT;
        else                       state_d = S_ADV;
      end
      S_ADV: if (mdio_done) state_d = S_CTL;
      S_CTL: if (mdio_done) begin
        tmr_clear = 1'b1;
        state_d   = S_AN_RD;
      end
      S_AN_RD: if (mdio_done) begin
        if (mdio_rdata[STAT_ANDONE]) begin
          tmr_clear = 1'b1;
          state_d   = S_LK_RD;
        end else begin
          tmr_fail = 1'b1;
          state_d  = S_AN_GAP;
        end
      end
      S_AN_GAP: begin
        if (exhausted) begin
          done_d  = 1'b1;
          res_d   = RES_AN_TMO;
          state_d = S_IDLE;
        end else if (!gap_busy) state_d = S_AN_RD;
      end
      S_LK_RD: if (mdio_done) begin
        if (mdio_rdata[STAT_LINK]) state_d = GIGA_EN ? S_GSTAT : S_RSTAT;
        else begin
          tmr_fail = 1'b1;
          state_d  = S_LK_GAP;
        end
      end
      S_LK_GAP: begin
        if (exhausted) begin
          done_d  = 1'b1;
          res_d   = RES_LINK_DN;
          state_d = S_IDLE;
        end else if (!gap_busy) state_d = S_LK_RD;
      end
      S_GSTAT: if (mdio_done) begin
        gstat_d = mdio_rdata;
        state_d = S_RSTAT;
      end
      S_RSTAT: if (mdio_done) begin
        ctrl_d           = ctrl_in;
        ctrl_d[GIGA_BIT] = mode.giga;
        ctrl_d[FAST_BIT] = mode.fast;
        ctrl_d[FULL_BIT] = mode.full;
        link_d           = 1'b1;
        done_d           = 1'b1;
        res_d            = RES_OK;
        state_d          = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      addr_q  <= 5'd0;
      gstat_q <= 16'h0000;
      ctrl_q  <= '0;
      link_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      gstat_q <= gstat_d;
      ctrl_q  <= ctrl_d;
      link_q  <= link_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign ctrl_out = ctrl_q;
  assign phy_addr = addr_q;
  assign link_up  = link_q;
  assign done     = done_q;
  assign result   = res_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)
                                  && $stable(mdio_wr) && $stable(mdio_wdata))); // R11
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !mdio_req); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R10
  AST_OK_MEANS_LINK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && result == RES_OK) |-> link_up); // R10
  AST_CTRL_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(ctrl_out) |-> (done && result == RES_OK)); // R9
  AST_GIGA_FAST_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ctrl_out[GIGA_BIT] && ctrl_out[FAST_BIT])); // R8

  generate
    if (!GIGA_EN) begin : g_chk_nogiga
      AST_NO_GIGA_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !ctrl_out[GIGA_BIT] && !(mdio_req && mdio_reg == REG_GSTAT)); // R7
    end
  endgenerate
endmodule

// File: tb/phy_link_resolver_tb_top.sv
`timescale 1ns/1ps
module plr_phy_model (
  input  logic        clk,
  input  logic        clr,
  input  logic        req,
  input  logic        wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regn,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        done,
  input  logic        present,
  input  logic [4:0]  cfg_addr,
  input  logic [15:0] cfg_id,
  input  logic        link_init,
  input  int          an_wait,
  input  int          link_wait,
  input  logic [3:0]  abil,
  input  logic [15:0] gstat,
  output int          n_wr,
  output int          n_grd,
  output int          viol,
  output logic [15:0] last_adv,
  output logic [15:0] last_ctl
);
  logic pend, s_wr, an_on;
  int lat, st_rd, k;
  logic [4:0] s_phy, s_reg;
  logic [15:0] s_wd, st;

  always @(negedge clk) begin
    if (clr) begin
      pend <= 0; done <= 0; n_wr <= 0; n_grd <= 0; viol <= 0; an_on <= 0;
      st_rd <= 0; last_adv <= 0; last_ctl <= 0; rdata <= 0; lat <= 0;
    end else if (done) begin
      done <= 0; pend <= 0;
    end else if (!pend) begin
      if (req) begin
        pend <= 1; lat <= $urandom_range(0, 2);
        s_phy <= phy; s_reg <= regn; s_wr <= wr; s_wd <= wdata;
      end
    end else begin
      if (!req || phy != s_phy || regn != s_reg || wr != s_wr || wdata != s_wd) viol <= viol + 1;
      if (lat > 0) lat <= lat - 1;
      else begin
        done <= 1; rdata <= 16'h0000;
        if (s_wr) begin
          n_wr <= n_wr + 1;
          if (s_reg == 5'd4) last_adv <= s_wd;
          if (s_reg == 5'd0) begin
            last_ctl <= s_wd;
            if (s_wd == 16'h1200) begin an_on <= 1; st_rd <= 0; end
          end
        end else if (!present || s_phy != cfg_addr) begin
          rdata <= s_phy[0] ? 16'hFFFF : 16'h0000;
        end else begin
          case (s_reg)
            5'd2:  rdata <= cfg_id;
            5'd10: begin rdata <= gstat; n_grd <= n_grd + 1; end
            5'd1: begin
              k = st_rd + 1;
              st = 16'h0000;
              st[14:11] = abil;
              st[5] = an_on && (k > an_wait);
              st[2] = link_init || (an_on && (k > an_wait + link_wait));
              if (an_on) st_rd <= k;
              rdata <= st;
            end
            default: rdata <= 16'h0000;
          endcase
        end
      end
    end
  end
endmodule

module phy_link_resolver_tb_top;
  localparam int PM = 4;
  localparam int PG = 3;
  localparam int FULL_B = 8, GIGA_B = 9, FAST_B = 11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, clr;
  logic [15:0] ctrl_in;
  logic present, link_init;
  logic [4:0] cfg_addr;
  logic [15:0] cfg_id, gstat;
  logic [3:0] abil;
  int an_wait, link_wait;

  logic req_a, wr_a, done_m_a, lu_a, dn_a;
  logic [4:0] phy_a, reg_a, pa_a;
  logic [15:0] wd_a, rd_a, co_a, adv_a, ctl_a;
  logic [1:0] res_a;
  int nwr_a, ngr_a, vio_a;

  logic req_b, wr_b, done_m_b, lu_b, dn_b;
  logic [4:0] phy_b, reg_b, pa_b;
  logic [15:0] wd_b, rd_b, co_b, adv_b, ctl_b;
  logic [1:0] res_b;
  int nwr_b, ngr_b, vio_b;

  int n_chk = 0, n_fail = 0;
  int cnt_a = 0, cnt_b = 0;
  logic [15:0] exp_ctrl_a, exp_ctrl_b;

  phy_link_resolver #(.POLL_GAP(PG), .POLL_MAX(PM), .GIGA_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mdio_req(req_a), .mdio_wr(wr_a), .mdio_phy(phy_a), .mdio_reg(reg_a),
    .mdio_wdata(wd_a), .mdio_rdata(rd_a), .mdio_done(done_m_a),
    .ctrl_in(ctrl_in), .ctrl_out(co_a), .phy_addr(pa_a), .link_up(lu_a),
    .done(dn_a), .result(res_a));

  phy_link_resolver #(.POLL_GAP(PG), .POLL_MAX(PM), .GIGA_EN(1'b0)) dut_nog_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mdio_req(req_b), .mdio_wr(wr_b), .mdio_phy(phy_b), .mdio_reg(reg_b),
    .mdio_wdata(wd_b), .mdio_rdata(rd_b), .mdio_done(done_m_b),
    .ctrl_in(ctrl_in), .ctrl_out(co_b), .phy_addr(pa_b), .link_up(lu_b),
    .done(dn_b), .result(res_b));

  plr_phy_model m_a (
    .clk(clk), .clr(clr), .req(req_a), .wr(wr_a), .phy(phy_a), .regn(reg_a),
    .wdata(wd_a), .rdata(rd_a), .done(done_m_a), .present(present),
    .cfg_addr(cfg_addr), .cfg_id(cfg_id), .link_init(link_init),
    .an_wait(an_wait), .link_wait(link_wait), .abil(abil), .gstat(gstat),
    .n_wr(nwr_a), .n_grd(ngr_a), .viol(vio_a), .last_adv(adv_a), .last_ctl(ctl_a));

  plr_phy_model m_b (
    .clk(clk), .clr(clr), .req(req_b), .wr(wr_b), .phy(phy_b), .regn(reg_b),
    .wdata(wd_b), .rdata(rd_b), .done(done_m_b), .present(present),
    .cfg_addr(cfg_addr), .cfg_id(cfg_id), .link_init(link_init),
    .an_wait(an_wait), .link_wait(link_wait), .abil(abil), .gstat(gstat),
    .n_wr(nwr_b), .n_grd(ngr_b), .viol(vio_b), .last_adv(adv_b), .last_ctl(ctl_b));

  always @(negedge clk) begin
    if (dn_a) cnt_a <= cnt_a + 1;
    if (dn_b) cnt_b <= cnt_b + 1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(input bit ge, input logic [15:0] gs, input logic [3:0] ab);
    if (ge && gs[11]) return 3'b101;  // {giga,fast,full}
    if (ge && gs[10]) return 3'b100;
    if (ab[3]) return 3'b011;         // status bit 14
    if (ab[1]) return 3'b001;         // status bit 12
    if (ab[2]) return 3'b010;         // status bit 13
    return 3'b000;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] ci, input logic [2:0] m);
    logic [15:0] r = ci;
    r[GIGA_B] = m[2];
    r[FAST_B] = m[1];
    r[FULL_B] = m[0];
    return r;
  endfunction

  function automatic int exp_result(input bit pr, input logic [15:0] id, input bit li, input int aw, input int lw);
    if (!pr || id == 16'hFFFF || id == 16'h0000) return 1;
    if (li) return 0;
    if (aw >= PM) return 2;
    if (lw > PM) return 3;
    return 0;
  endfunction

  task automatic check_dut(input string nm, input bit ge, input int er, input logic [1:0] res,
                           input logic [4:0] pa, input logic lu, input logic [15:0] co,
                           input int nwr, input int ngr, input int vio,
                           input logic [15:0] adv, input logic [15:0] ctl,
                           inout logic [15:0] expc);
    chk({nm, " R10 result"}, res, er);
    chk({nm, " R10 link_up"}, lu, (er == 0));
    chk({nm, " R11 request hold"}, vio, 0);
    if (er == 0) begin
      chk({nm, " R1 phy_addr"}, pa, cfg_addr);
      expc = merge(ctrl_in, exp_mode(ge, gstat, abil));
      chk({nm, " R8 R9 ctrl_out"}, co, expc);
      if (ge) chk({nm, " R7 gstat reads"}, ngr, 1);
    end else begin
      if (er == 1) chk({nm, " R2 ctrl_out kept"}, co, expc);
      else         chk({nm, " R5 R6 ctrl_out kept"}, co, expc);
    end
    if (!ge) chk({nm, " R7 no gstat read"}, ngr, 0);
    if (er != 1) begin
      if (link_init) chk({nm, " R3 no writes"}, nwr, 0);
      else begin
        chk({nm, " R4 write count"}, nwr, 2);
        chk({nm, " R4 adv value"}, adv, 16'h01E1);
        chk({nm, " R4 ctl value"}, ctl, 16'h1200);
      end
    end
  endtask

  task automatic run_case(input bit pr, input logic [4:0] ad, input logic [15:0] id, input bit li,
                          input int aw, input int lw, input logic [3:0] ab, input logic [15:0] gs);
    int ba, bb, er;
    present = pr; cfg_addr = ad; cfg_id = id; link_init = li;
    an_wait = aw; link_wait = lw; abil = ab; gstat = gs;
    ctrl_in = 16'($urandom);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    ba = cnt_a; bb = cnt_b;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (cnt_a == ba || cnt_b == bb) @(negedge clk);
    @(negedge clk);
    er = exp_result(pr, id, li, aw, lw);
    check_dut("giga", 1'b1, er, res_a, pa_a, lu_a, co_a, nwr_a, ngr_a, vio_a, adv_a, ctl_a, exp_ctrl_a);
    check_dut("nogiga", 1'b0, er, res_b, pa_b, lu_b, co_b, nwr_b, ngr_b, vio_b, adv_b, ctl_b, exp_ctrl_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=no_done expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; clr = 1'b1; ctrl_in = '0;
    present = 0; cfg_addr = 0; cfg_id = 0; link_init = 0;
    an_wait = 0; link_wait = 0; abil = 0; gstat = 0;
    exp_ctrl_a = '0; exp_ctrl_b = '0;
    repeat (5) @(negedge clk);
    clr = 1'b0; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 done", {dn_a, dn_b}, 0);
    chk("R12 link_up", {lu_a, lu_b}, 0);
    chk("R12 mdio_req", {req_a, req_b}, 0);
    chk("R12 result", {res_a, res_b}, 0);
    chk("R12 ctrl_out", {co_a, co_b}, 0);

    // directed corners
    run_case(1, 5'd0,  16'h0141, 1, 0, 0, 4'b1000, 16'h0800); // R3 link already up, 1000 full
    run_case(1, 5'd31, 16'h1234, 0, 0, 0, 4'b0110, 16'h0400); // R1 last address, R8 10F over 100H
    run_case(0, 5'd0,  16'h1234, 0, 0, 0, 4'b0000, 16'h0000); // R2 nothing present
    run_case(1, 5'd5,  16'hFFFF, 1, 0, 0, 4'b1111, 16'h0C00); // R1 all-ones rejected
    run_case(1, 5'd6,  16'h0000, 1, 0, 0, 4'b1111, 16'h0C00); // R1 all-zeros rejected
    run_case(1, 5'd2,  16'h00AA, 0, PM,   0, 4'b1000, 16'h0000); // R5 timeout at budget
    run_case(1, 5'd2,  16'h00AA, 0, PM-1, 0, 4'b1000, 16'h0000); // R5 last poll succeeds
    run_case(1, 5'd3,  16'h00AB, 0, 1, PM,   4'b0100, 16'h0400); // R6 last link poll succeeds
    run_case(1, 5'd3,  16'h00AB, 0, 1, PM+1, 4'b0100, 16'h0400); // R6 link down
    run_case(1, 5'd1,  16'h7777, 1, 0, 0, 4'b0001, 16'h0C00); // R7 both giga bits, R8 10H
    run_case(1, 5'd4,  16'h7778, 1, 0, 0, 4'b0000, 16'h0000); // R8 nothing set

    for (int i = 0; i < 40; i++) begin
      logic [15:0] id;
      id = 16'($urandom);
      case ($urandom % 8)
        0: id = 16'hFFFF;
        1: id = 16'h0000;
        default: ;
      endcase
      run_case(($urandom % 8) != 0, 5'($urandom), id, 1'($urandom),
               $urandom_range(0, PM), $urandom_range(0, PM + 1),
               4'($urandom), 16'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule